// File: doc/BRIEF.md
# Configurable Rounding and Saturation Unit

This block conditions a 44-bit two's-complement word after it leaves a multiplier or an accumulator. It can first round the word to a chosen quantum and then clamp it into a narrower signed range. When the block follows an accumulator, it is applied once to the final sum of products, not to each partial product. The rounding point, the clamp width and the clamp style are elaboration parameters. No input changes them at run time.

Rounding is round-half-up at bit `RND_POS`, which may be any bit from 6 to 21. The unit adds half a quantum and then clears every bit below `RND_POS`. The sign bit of the clamped range is `SAT_POS`, which may be any bit from 28 to 43. The clamped value occupies bits `SAT_POS..0` and is sign-extended to 44 bits at the output.

The clamp style has two settings:
- **Asymmetric**: the full two's-complement range is used.
- **Symmetric**: the most negative code is excluded, so the negative rail mirrors the positive rail.

Rounding always comes before the range check, so a carry out of rounding can itself cause a clamp. The result is registered with one cycle of latency. It carries a valid bit and an overflow flag.

Top module: `rsu_round_sat`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock, and `out_data` and `out_ovf` belong to the word accepted on that earlier edge. While `rst_n` is low, `out_valid`, `out_ovf` and `out_data` are all 0.
- R2: With `ROUND_EN`=1, the unit adds 2^(`RND_POS`-1) to the sign-extended input and then forces bits below `RND_POS` to 0. Ties therefore go toward plus infinity; for example, -1.5 quanta becomes -1 quantum.
- R3: With `ROUND_EN`=0, an input that lies inside the clamp range appears on `out_data` bit for bit, with `out_ovf`=0.
- R4: Let Q be `RND_POS` when rounding is on and 0 when it is off. If the rounded value exceeds 2^`SAT_POS` - 2^Q, then `out_data` is exactly that maximum and `out_ovf` is 1.
- R5: In asymmetric mode (`SAT_STYLE`=`SAT_ASYM`), a rounded value below -2^`SAT_POS` gives `out_data` = -2^`SAT_POS` (44-bit two's complement) and `out_ovf`=1. A value exactly equal to -2^`SAT_POS` passes with `out_ovf`=0.
- R6: In symmetric mode (`SAT_STYLE`=`SAT_SYM`), the negative rail is -2^`SAT_POS` + 2^Q. A rounded value equal to -2^`SAT_POS` is itself treated as overflow and clamps to that rail with `out_ovf`=1.
- R7: The range check is applied to the rounded value. An input just inside the positive rail whose rounding carries past it is clamped with `out_ovf`=1. An input whose rounding lands exactly on the rail passes with `out_ovf`=0.
- R8: A rounded value inside the rails appears on `out_data` unchanged and sign-extended to 44 bits, with `out_ovf`=0. Consecutive valid words are handled one per clock.
- R9: In any cycle where `out_valid` is 0, `out_ovf` is also 0. A cycle with `in_valid` low gives `out_valid`=0 and `out_ovf`=0 on the next clock, whatever value `in_data` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_data` in this cycle |
| in_data | input | 44 | Two's-complement word to condition |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_data | output | 44 | Rounded and clamped word, sign-extended |
| out_ovf | output | 1 | The word on `out_data` was clamped |

## Verification
The hardest case to reach is the point where rounding alone decides whether a clamp happens. Examples are an input a fraction of a quantum below the positive rail, and the exact most negative code under symmetric clamping. The stimulus lands on these points directly: it uses inputs within one quantum of each rail, on both sides of the half-quantum tie. The same words are also fed to a second instance that does not round and clamps asymmetrically, so the two clamp styles can be compared on identical inputs. A back-to-back stream confirms that each result pairs with the word accepted one clock earlier.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

   typedef enum logic {
      SAT_ASYM = 1'b0,
      SAT_SYM  = 1'b1
   } sat_style_e;

   // fixed placement windows for the rounding point
   localparam int RND_WIN_LO = 6;
   localparam int RND_WIN_HI = 21;
   localparam int WIN_SPAN   = 16;

   // positive rail: 2^s - 2^q, returned as 64-bit pattern
   function automatic logic [63:0] rail_hi(input int s, input int q);
      return (64'd1 << s) - (64'd1 << q);
   endfunction

   // negative rail: -2^s, plus one quantum when symmetric
   function automatic logic [63:0] rail_lo(input int s, input int q, input sat_style_e st);
      logic [63:0] base;
      base = ~(64'd1 << s) + 64'd1;
      return (st == SAT_SYM) ? base + (64'd1 << q) : base;
   endfunction

endpackage

// File: rtl/rsu_rounder.sv
module rsu_rounder #(
   parameter int DATA_W   = 44,
   parameter bit ROUND_EN = 1'b1,
   parameter int RND_POS  = 8
) (
   input  logic [DATA_W-1:0] in_word,
   output logic [DATA_W:0]   rnd_word
);

   localparam int EXT_W = DATA_W + 1;

   logic [EXT_W-1:0] ext_word;

   assign ext_word = {in_word[DATA_W-1], in_word};

   generate
      if (ROUND_EN) begin : g_round
         localparam logic [EXT_W-1:0] HALF_Q = EXT_W'(1) << (RND_POS - 1);
         localparam logic [EXT_W-1:0] KEEP_M = ~((EXT_W'(1) << RND_POS) - EXT_W'(1));
         logic [EXT_W-1:0] biased;
         assign biased   = ext_word + HALF_Q;
         assign rnd_word = biased & KEEP_M;
      end else begin : g_pass
         assign rnd_word = ext_word;
      end
   endgenerate

endmodule

// File: rtl/rsu_ovf_detect.sv
module rsu_ovf_detect
   import rsu_pkg::*;
#(
   parameter int         DATA_W    = 44,
   parameter int         SAT_POS   = 35,
   parameter sat_style_e SAT_STYLE = SAT_SYM
) (
   input  logic [DATA_W:0] rnd_word,
   output logic            pos_ovf,
   output logic            neg_ovf
);

   localparam int  HI_W   = DATA_W - SAT_POS + 1;
   localparam bit  IS_SYM = (SAT_STYLE == SAT_SYM);

   logic [HI_W-1:0]    hi_bits;
   logic [SAT_POS-1:0] lo_bits;
   logic               sign_b;
   logic               hi_all1;
   logic               hi_any1;
   logic               min_hit;

   assign hi_bits = rnd_word[DATA_W:SAT_POS];
   assign lo_bits = rnd_word[SAT_POS-1:0];
   assign sign_b  = rnd_word[DATA_W];
   assign hi_all1 = &hi_bits;
   assign hi_any1 = |hi_bits;

   // the most negative code of the narrow range
   assign min_hit = IS_SYM ? (hi_all1 && (lo_bits == '0)) : 1'b0;

   assign pos_ovf = !sign_b && hi_any1;
   assign neg_ovf = sign_b && (!hi_all1 || min_hit);

endmodule

// File: rtl/rsu_clamp_gen.sv
module rsu_clamp_gen
   import rsu_pkg::*;
#(
   parameter int         DATA_W    = 44,
   parameter int         SAT_POS   = 35,
   parameter int         QUANT     = 8,
   parameter sat_style_e SAT_STYLE = SAT_SYM
) (
   input  logic [DATA_W:0]   rnd_word,
   input  logic              pos_ovf,
   input  logic              neg_ovf,
   output logic [DATA_W-1:0] clamp_word
);

   localparam logic [DATA_W-1:0] TOP_RAIL = DATA_W'(rail_hi(SAT_POS, QUANT));
   localparam logic [DATA_W-1:0] BOT_RAIL = DATA_W'(rail_lo(SAT_POS, QUANT, SAT_STYLE));

   logic [DATA_W-1:0] narrow;

   // bits above SAT_POS are sign copies once in range
   assign narrow = {{(DATA_W - SAT_POS){rnd_word[SAT_POS]}}, rnd_word[SAT_POS-1:0]};

   always_comb begin
      unique case ({pos_ovf, neg_ovf})
         2'b10:   clamp_word = TOP_RAIL;
         2'b01:   clamp_word = BOT_RAIL;
         default: clamp_word = narrow;
      endcase
   end

endmodule

// File: rtl/rsu_round_sat.sv
module rsu_round_sat
   import rsu_pkg::*;
#(
   parameter int         DATA_W    = 44,
   parameter bit         ROUND_EN  = 1'b1,
   parameter int         RND_POS   = 8,
   parameter int         SAT_POS   = 35,
   parameter sat_style_e SAT_STYLE = SAT_SYM
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_ovf
);

   localparam int QUANT      = ROUND_EN ? RND_POS : 0;
   localparam int SAT_WIN_LO = DATA_W - WIN_SPAN;
   localparam int SAT_WIN_HI = DATA_W - 1;

   generate
      if (DATA_W < RND_WIN_HI + WIN_SPAN + 1 || DATA_W > 62) begin : g_bad_width
         $error("rsu_round_sat: DATA_W out of supported range");
      end
      if (RND_POS < RND_WIN_LO || RND_POS > RND_WIN_HI) begin : g_bad_rnd
         $error("rsu_round_sat: RND_POS outside rounding window");
      end
      if (SAT_POS < SAT_WIN_LO || SAT_POS > SAT_WIN_HI) begin : g_bad_sat
         $error("rsu_round_sat: SAT_POS outside saturation window");
      end
   endgenerate

   logic [DATA_W:0]   rnd_word;
   logic              pos_ovf;
   logic              neg_ovf;
   logic [DATA_W-1:0] clamp_word;

   rsu_rounder #(
      .DATA_W   (DATA_W),
      .ROUND_EN (ROUND_EN),
      .RND_POS  (RND_POS)
   ) rounder_i (
      .in_word  (in_data),
      .rnd_word (rnd_word)
   );

   rsu_ovf_detect #(
      .DATA_W    (DATA_W),
      .SAT_POS   (SAT_POS),
      .SAT_STYLE (SAT_STYLE)
   ) detect_i (
      .rnd_word (rnd_word),
      .pos_ovf  (pos_ovf),
      .neg_ovf  (neg_ovf)
   );

   rsu_clamp_gen #(
      .DATA_W    (DATA_W),
      .SAT_POS   (SAT_POS),
      .QUANT     (QUANT),
      .SAT_STYLE (SAT_STYLE)
   ) clamp_i (
      .rnd_word   (rnd_word),
      .pos_ovf    (pos_ovf),
      .neg_ovf    (neg_ovf),
      .clamp_word (clamp_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_ovf   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         out_ovf   <= in_valid && (pos_ovf || neg_ovf);
         if (in_valid) begin
            out_data <= clamp_word;
         end
      end
   end

endmodule

// File: rtl/rsu_round_sat_chk.sv
module rsu_round_sat_chk
   import rsu_pkg::*;
#(
   parameter int         DATA_W    = 44,
   parameter bit         ROUND_EN  = 1'b1,
   parameter int         RND_POS   = 8,
   parameter int         SAT_POS   = 35,
   parameter sat_style_e SAT_STYLE = SAT_SYM
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              out_ovf
);

   localparam int QUANT = ROUND_EN ? RND_POS : 0;
   localparam logic [DATA_W-1:0] TOP_RAIL  = DATA_W'(rail_hi(SAT_POS, QUANT));
   localparam logic [DATA_W-1:0] BOT_RAIL  = DATA_W'(rail_lo(SAT_POS, QUANT, SAT_STYLE));
   localparam logic [DATA_W-1:0] FULL_NEG  = DATA_W'(rail_lo(SAT_POS, QUANT, SAT_ASYM));

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R1

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_ovf)); // R9

   AST_OVF_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovf |-> out_valid); // R9

   AST_OVF_ON_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovf |-> (out_data == TOP_RAIL || out_data == BOT_RAIL)); // R4

   AST_WITHIN_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($signed(out_data) <= $signed(TOP_RAIL) &&
                     $signed(out_data) >= $signed(BOT_RAIL))); // R8

   generate
      if (ROUND_EN) begin : g_quant_chk
         AST_QUANT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_data[RND_POS-1:0] == '0)); // R2
      end
      if (SAT_STYLE == SAT_SYM) begin : g_sym_chk
         AST_NO_FULL_NEG: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_data != FULL_NEG)); // R6
      end
   endgenerate

endmodule

bind rsu_round_sat rsu_round_sat_chk #(
   .DATA_W    (DATA_W),
   .ROUND_EN  (ROUND_EN),
   .RND_POS   (RND_POS),
   .SAT_POS   (SAT_POS),
   .SAT_STYLE (SAT_STYLE)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_ovf   (out_ovf)
);

// File: tb/rsu_round_sat_tb_top.sv
`timescale 1ns/1ps
module rsu_round_sat_tb_top;
   import rsu_pkg::*;

   localparam int W = 44;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic         s_v, s_o, a_v, a_o;
   logic [W-1:0] s_d, a_d;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   // symmetric, rounding at bit 8, clamp sign bit 35
   rsu_round_sat dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(s_v), .out_data(s_d), .out_ovf(s_o));

   // asymmetric, no rounding, clamp sign bit 35
   rsu_round_sat #(.ROUND_EN(1'b0), .SAT_POS(35), .SAT_STYLE(SAT_ASYM)) dut_asym_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(a_v), .out_data(a_d), .out_ovf(a_o));

   // independent reference: returns {ovf, data}
   function automatic logic [W:0] model(input logic [W-1:0] d, input bit sym,
                                        input bit ren, input int rp, input int sp);
      longint v, mx, mn;
      int q;
      logic [63:0] t;
      v = longint'($signed(d));
      q = ren ? rp : 0;
      if (ren) v = ((v + (64'sd1 <<< (rp - 1))) >>> rp) <<< rp;
      mx = (64'sd1 <<< sp) - (64'sd1 <<< q);
      mn = -(64'sd1 <<< sp) + (sym ? (64'sd1 <<< q) : 64'sd0);
      if (v > mx) begin t = 64'(mx); return {1'b1, t[W-1:0]}; end
      if (v < mn) begin t = 64'(mn); return {1'b1, t[W-1:0]}; end
      t = 64'(v);
      return {1'b0, t[W-1:0]};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [W-1:0] d);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // compare both instances against the reference for the word just sent
   task automatic check_model(input string req, input logic [W-1:0] d);
      logic [W:0] es, ea;
      es = model(d, 1'b1, 1'b1, 8, 35);
      ea = model(d, 1'b0, 1'b0, 8, 35);
      check(req, "sym valid", 64'(s_v), 64'd1);
      check(req, "sym data", 64'(s_d), 64'(es[W-1:0]));
      check(req, "sym ovf", 64'(s_o), 64'(es[W]));
      check(req, "asym data", 64'(a_d), 64'(ea[W-1:0]));
      check(req, "asym ovf", 64'(a_o), 64'(ea[W]));
   endtask

   task automatic t_reset;
      check("R1", "reset valid", 64'({s_v, a_v}), 64'd0);
      check("R1", "reset ovf", 64'({s_o, a_o}), 64'd0);
      check("R1", "reset data", 64'(s_d | a_d), 64'd0);
   endtask

   task automatic t_latency;
      send(44'h0000_0001_234);
      check("R1", "valid one cycle later", 64'({s_v, a_v}), 64'd3);
      check("R3", "asym passthrough", 64'(a_d), 64'h0000_0001_234);
      @(negedge clk);
      check("R1", "valid drops after", 64'({s_v, a_v}), 64'd0);
   endtask

   task automatic t_round;
      send(44'h000_0000_0180);
      check("R2", "1.5 quanta up", 64'(s_d), 64'h000_0000_0200);
      check("R3", "asym unrounded", 64'(a_d), 64'h000_0000_0180);
      send(44'h000_0000_017F);
      check("R2", "below half down", 64'(s_d), 64'h000_0000_0100);
      send(44'hFFF_FFFF_FE80);
      check("R2", "-1.5 quanta to -1", 64'(s_d), 64'hFFF_FFFF_FF00);
      check("R3", "asym negative pass", 64'(a_d), 64'hFFF_FFFF_FE80);
      send(44'hFFF_FFFF_FFFF);
      check_model("R2", 44'hFFF_FFFF_FFFF);
   endtask

   task automatic t_pos_sat;
      send(44'h592_6AC0_1342);
      check("R4", "sym top rail", 64'(s_d), 64'h007_FFFF_FF00);
      check("R4", "sym ovf", 64'(s_o), 64'd1);
      check("R4", "asym top rail", 64'(a_d), 64'h007_FFFF_FFFF);
      check("R4", "asym ovf", 64'(a_o), 64'd1);
      send(44'h008_0000_0000);
      check("R4", "asym just over", 64'({a_o, 4'h0, a_d}), {16'h0, 4'h1, 4'h0, 44'h007_FFFF_FFFF} >> 0);
      send(44'h007_FFFF_FFFF);
      check("R8", "asym exact max ovf", 64'(a_o), 64'd0);
      send(44'h7FF_FFFF_FFFF);
      check_model("R4", 44'h7FF_FFFF_FFFF);
   endtask

   task automatic t_neg_sat;
      send(44'hA00_0000_0000);
      check("R6", "sym bottom rail", 64'(s_d), 64'hFF8_0000_0100);
      check("R5", "asym bottom rail", 64'(a_d), 64'hFF8_0000_0000);
      check("R5", "asym ovf", 64'(a_o), 64'd1);
      send(44'hFF7_FFFF_FFFF);
      check("R5", "asym one below", 64'(a_d), 64'hFF8_0000_0000);
   endtask

   task automatic t_sym_min;
      send(44'hFF8_0000_0000);
      check("R6", "sym min code clamps", 64'(s_d), 64'hFF8_0000_0100);
      check("R6", "sym min code ovf", 64'(s_o), 64'd1);
      check("R5", "asym min code passes", 64'(a_d), 64'hFF8_0000_0000);
      check("R5", "asym min code no ovf", 64'(a_o), 64'd0);
   endtask

   task automatic t_round_then_sat;
      send(44'h007_FFFF_FF80);
      check("R7", "carry past rail", 64'(s_d), 64'h007_FFFF_FF00);
      check("R7", "carry past rail ovf", 64'(s_o), 64'd1);
      check("R7", "asym same word no ovf", 64'(a_o), 64'd0);
      send(44'h007_FFFF_FF7F);
      check("R7", "lands on rail", 64'(s_d), 64'h007_FFFF_FF00);
      check("R7", "lands on rail no ovf", 64'(s_o), 64'd0);
   endtask

   task automatic t_in_range;
      logic [W-1:0] pats [5] = '{44'h0, 44'h000_1234_5678, 44'hFFF_EDCB_A988,
                                 44'h003_0000_00C0, 44'hFFC_0000_0040};
      foreach (pats[i]) begin
         send(pats[i]);
         check_model("R8", pats[i]);
      end
   endtask

   task automatic t_idle;
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 44'h7FF_FFFF_FFFF;
      @(negedge clk);
      check("R9", "idle valid low", 64'({s_v, a_v}), 64'd0);
      check("R9", "idle ovf low", 64'({s_o, a_o}), 64'd0);
   endtask

   task automatic t_stream;
      logic [W-1:0] ws [4] = '{44'h010_0000_0000, 44'h000_0000_0280,
                               44'hF00_0000_0000, 44'hFFF_FFFF_FF80};
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = ws[0];
      for (int i = 1; i <= 4; i++) begin
         @(negedge clk);
         check_model("R8", ws[i-1]);
         if (i < 4) in_data = ws[i];
         else in_valid = 1'b0;
      end
   endtask

   task automatic report;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_latency();
      t_round();
      t_pos_sat();
      t_neg_sat();
      t_sym_min();
      t_round_then_sat();
      t_in_range();
      t_idle();
      t_stream();
      finished = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
         $finish;
      end
   end

endmodule